// File: doc/BRIEF.md
# Multichannel SPI DAC/ADC Frame Sequencer

This block runs one audio frame on a pair of SPI data converters that share a single serial clock and data-out line. A frame covers 2, 4 or 8 channel slots. The frame length is picked by a two-bit count code.

In each slot the block does two transfers, one after the other, each under its own chip select:

- **DAC write.** A 32-bit frame that carries the write-and-update command, the remapped physical channel address and the slot's 16-bit sample. Whatever arrives on the return line during this transfer is thrown away.
- **ADC command.** A 16-bit frame that asks for a conversion and clocks back the result of an earlier request.

The DAC address is passed through a fixed interleave, so that logical channels 0 to 7 appear on physical outputs 6, 4, 2, 0, 1, 3, 5, 7. This makes the outputs come out in ascending order at the connector.

The ADC answers each command two commands late. The sequencer therefore asks for channel (slot+2) mod N in slot `slot`. The result it receives in that slot belongs to channel `slot`. It presents that result with a one-cycle strobe and the channel tag.

The last two requests of any frame are always channels 0 and 1, whatever N is. So the pipeline stays aligned across frames and across changes of channel count. Only the first two results after reset carry no valid data, and those are suppressed.

The frame's samples come in as one parallel bus. Word w holds channel 2w in its low half and channel 2w+1 in its high half. The bus is latched when the frame starts.

Top module: `spi_conv_frame_seq`

## Requirements
- R1: While reset is asserted and after it, until a frame starts, both chip selects are high, `sclk` is low, `busy` is low and `adc_valid` is low.
- R2: The frame performs N DAC transfers and N ADC transfers, where N is set by `chan_cfg`: 2'b11 gives 8, 2'b01 gives 4, and both 2'b00 and 2'b10 give 2.
- R3: The DAC address field, frame bits [23:20], carries 6,4,2,0,1,3,5,7 for slots 0..7.
- R4: Each DAC transfer shifts exactly 32 bits MSB first. Bits [31:28] are 0, bits [27:24] hold command 4'h3, and bits [3:0] are 0.
- R5: DAC frame bits [19:4] of slot k carry `dac_samples[16k+15:16k]`. This means the low half of each 32-bit word is sent before its high half.
- R6: The two chip selects are never low together, and `sclk` is low whenever both are high. Data is launched on the falling edge of `sclk` and sampled on the rising edge.
- R7: The ADC transfer of slot k shifts exactly 16 bits MSB first and requests channel (k+2) mod N in bits [14:12]. All its other bits are 0.
- R8: After the ADC transfer of slot k, `adc_valid` pulses for one cycle with `adc_chan`=k and `adc_data` holding the 16 bits received during that transfer, MSB first. A DAC transfer never raises the strobe.
- R9: The first two ADC transfers after reset raise no strobe. All later ones do.
- R10: `frame_start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a frame when idle |
| chan_cfg | input | 2 | Channel count code |
| dac_samples | input | 128 | 16-bit samples for slots 0..7, slot 0 in the LSBs |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Shared serial clock |
| mosi | output | 1 | Shared serial data to the converters |
| miso | input | 1 | Serial data from the converters |
| dac_cs_n | output | 1 | DAC chip select, active low |
| adc_cs_n | output | 1 | ADC chip select, active low |
| adc_valid | output | 1 | One-cycle ADC result strobe |
| adc_chan | output | 3 | Channel of the presented result |
| adc_data | output | 16 | ADC result |

## Verification
Two functions can land in the same cycle:

- the result strobe of slot k, raised one cycle after the ADC chip select releases, and
- the launch of the next DAC write for slot k+1.

The bench provokes this in every multi-slot frame. Meanwhile the shared return line carries a toggling junk pattern during each DAC transfer, so a strobe raised or mis-tagged at that boundary would show the junk.

The bench judges the outcome by comparing the strobe's channel and data with values produced by a slave model. That model applies the two-command lag itself. The bench also checks that the DAC frame captured for the following slot holds the right address and sample.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_DAC_GO,
      S_DAC_WAIT,
      S_ADC_GO,
      S_ADC_WAIT
   } seq_state_t;

   localparam int LEN_W       = 6;
   localparam int DAC_FRAME_W = 32;
   localparam int ADC_FRAME_W = 16;
   localparam logic [3:0] DAC_CMD_WR_UPD = 4'h3;

   // Channel count code to (count - 1)
   function automatic logic [2:0] last_slot(input logic [1:0] cfg);
      case (cfg)
         2'b11:   return 3'd7;
         2'b01:   return 3'd3;
         default: return 3'd1;
      endcase
   endfunction
endpackage

// File: rtl/cfs_addr_map.sv
module cfs_addr_map (
   input  logic [2:0] lch,
   output logic [3:0] paddr
);
   // Lower half goes to descending even addresses, upper half to ascending odd ones
   always_comb begin
      if (lch[2]) paddr = {1'b0, lch[1:0], 1'b1};
      else        paddr = {1'b0, ~lch[1:0], 1'b0};
   end
endmodule

// File: rtl/cfs_shifter.sv
module cfs_shifter #(
   parameter int FRAME_W = 32,
   parameter int RX_W    = 16,
   parameter int HALF    = 2,
   parameter int LEN_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LEN_W-1:0]   len,
   input  logic [FRAME_W-1:0] tx,
   input  logic               miso,
   output logic               sclk,
   output logic               mosi,
   output logic               active,
   output logic               done,
   output logic [RX_W-1:0]    rx
);
   localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (HALF < 1) begin : g_bad_half
         $error("HALF must be at least 1");
      end
      if (RX_W < 2 || RX_W > FRAME_W) begin : g_bad_rx
         $error("RX_W out of range");
      end
   endgenerate

   logic [FRAME_W-1:0] sh;
   logic [LEN_W-1:0]   left;
   logic [CNT_W-1:0]   cnt;

   assign mosi = sh[FRAME_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh     <= '0;
         left   <= '0;
         cnt    <= '0;
         sclk   <= 1'b0;
         active <= 1'b0;
         done   <= 1'b0;
         rx     <= '0;
      end else begin
         done <= 1'b0;
         if (start && !active) begin
            active <= 1'b1;
            sh     <= tx << (LEN_W'(FRAME_W) - len);
            left   <= len;
            cnt    <= '0;
            sclk   <= 1'b0;
            rx     <= '0;
         end else if (active) begin
            if (cnt == CNT_W'(HALF - 1)) begin
               cnt <= '0;
               if (!sclk) begin
                  sclk <= 1'b1;
                  rx   <= {rx[RX_W-2:0], miso};
               end else begin
                  sclk <= 1'b0;
                  sh   <= {sh[FRAME_W-2:0], 1'b0};
                  left <= left - 1'b1;
                  if (left == LEN_W'(1)) begin
                     active <= 1'b0;
                     done   <= 1'b1;
                  end
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cfs_result_align.sv
module cfs_result_align #(
   parameter int RES_W = 16,
   parameter int CH_W  = 3,
   parameter int LAG   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [CH_W-1:0]  chan,
   input  logic [RES_W-1:0] data,
   output logic             valid,
   output logic [CH_W-1:0]  vchan,
   output logic [RES_W-1:0] vdata
);
   localparam int PC_W = $clog2(LAG + 1);

   logic [PC_W-1:0] primed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         primed <= '0;
         valid  <= 1'b0;
         vchan  <= '0;
         vdata  <= '0;
      end else begin
         valid <= 1'b0;
         if (capture) begin
            if (primed == PC_W'(LAG)) begin
               valid <= 1'b1;
               vchan <= chan;
               vdata <= data;
            end else begin
               primed <= primed + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_conv_frame_seq.sv
module spi_conv_frame_seq
   import cfs_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int MAX_CH   = 8,
   parameter int HALF_DIV = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_start,
   input  logic [1:0]                 chan_cfg,
   input  logic [MAX_CH*SAMPLE_W-1:0] dac_samples,
   output logic                       busy,
   output logic                       sclk,
   output logic                       mosi,
   input  logic                       miso,
   output logic                       dac_cs_n,
   output logic                       adc_cs_n,
   output logic                       adc_valid,
   output logic [2:0]                 adc_chan,
   output logic [SAMPLE_W-1:0]        adc_data
);
   localparam int CH_W = $clog2(MAX_CH);

   generate
      if (MAX_CH != 8) begin : g_bad_ch
         $error("address map covers exactly 8 channels");
      end
      if (SAMPLE_W != 16) begin : g_bad_w
         $error("frame layout assumes 16-bit samples");
      end
   endgenerate

   seq_state_t                 state;
   logic [CH_W-1:0]            slot, last;
   logic [MAX_CH*SAMPLE_W-1:0] samples_q;
   logic [SAMPLE_W-1:0]        samp_arr [MAX_CH];
   logic                       sel_adc;
   logic                       sh_start, sh_active, sh_done;
   logic [SAMPLE_W-1:0]        sh_rx;
   logic [3:0]                 paddr;
   logic [CH_W-1:0]            req_ch;
   logic [DAC_FRAME_W-1:0]     dac_frame, adc_frame, tx_word;
   logic [LEN_W-1:0]           tx_len;

   for (genvar g = 0; g < MAX_CH; g++) begin : g_unpack
      assign samp_arr[g] = samples_q[g*SAMPLE_W +: SAMPLE_W];
   end

   cfs_addr_map u_map (.lch(slot), .paddr(paddr));

   assign req_ch    = CH_W'(slot + CH_W'(2)) & last;
   assign dac_frame = {4'h0, DAC_CMD_WR_UPD, paddr, samp_arr[slot], 4'h0};
   assign adc_frame = {16'h0, 1'b0, req_ch, 12'h000};
   assign sh_start  = (state == S_DAC_GO) || (state == S_ADC_GO);
   assign tx_word   = (state == S_ADC_GO) ? adc_frame : dac_frame;
   assign tx_len    = (state == S_ADC_GO) ? LEN_W'(ADC_FRAME_W) : LEN_W'(DAC_FRAME_W);
   assign busy      = (state != S_IDLE);
   assign dac_cs_n  = !(sh_active && !sel_adc);
   assign adc_cs_n  = !(sh_active && sel_adc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         slot      <= '0;
         last      <= '0;
         samples_q <= '0;
         sel_adc   <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (frame_start) begin
               samples_q <= dac_samples;
               last      <= last_slot(chan_cfg);
               slot      <= '0;
               state     <= S_DAC_GO;
            end
            S_DAC_GO: begin
               sel_adc <= 1'b0;
               state   <= S_DAC_WAIT;
            end
            S_DAC_WAIT: if (sh_done) state <= S_ADC_GO;
            S_ADC_GO: begin
               sel_adc <= 1'b1;
               state   <= S_ADC_WAIT;
            end
            S_ADC_WAIT: if (sh_done) begin
               if (slot == last) state <= S_IDLE;
               else begin
                  slot  <= slot + 1'b1;
                  state <= S_DAC_GO;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   cfs_shifter #(
      .FRAME_W(DAC_FRAME_W), .RX_W(SAMPLE_W), .HALF(HALF_DIV), .LEN_W(LEN_W)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .len(tx_len), .tx(tx_word),
      .miso(miso), .sclk(sclk), .mosi(mosi), .active(sh_active), .done(sh_done),
      .rx(sh_rx)
   );

   cfs_result_align #(.RES_W(SAMPLE_W), .CH_W(CH_W), .LAG(2)) u_align (
      .clk(clk), .rst_n(rst_n),
      .capture((state == S_ADC_WAIT) && sh_done),
      .chan(slot), .data(sh_rx),
      .valid(adc_valid), .vchan(adc_chan), .vdata(adc_data)
   );
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic dac_cs_n,
   input logic adc_cs_n,
   input logic sclk,
   input logic adc_valid
);
   logic       adc_cs_q;
   logic [1:0] adc_done_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         adc_cs_q     <= 1'b1;
         adc_done_cnt <= '0;
      end else begin
         adc_cs_q <= adc_cs_n;
         if (adc_cs_n && !adc_cs_q && adc_done_cnt != 2'd3)
            adc_done_cnt <= adc_done_cnt + 1'b1;
      end
   end

   a_r6_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dac_cs_n && !adc_cs_n));

   a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_cs_n && adc_cs_n) |-> !sclk);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dac_cs_n && adc_cs_n && !sclk));

   a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      adc_valid |=> !adc_valid);

   a_r8_strobe_after_adc: assert property (@(posedge clk) disable iff (!rst_n)
      adc_valid |-> ($past(adc_cs_n, 1) && !$past(adc_cs_n, 2)));

   a_r9_primed: assert property (@(posedge clk) disable iff (!rst_n)
      adc_valid |-> (adc_done_cnt == 2'd3));
endmodule

bind spi_conv_frame_seq cfs_checker u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .dac_cs_n(dac_cs_n),
   .adc_cs_n(adc_cs_n), .sclk(sclk), .adc_valid(adc_valid)
);

// File: tb/sim_spi_conv_frame_seq.sv
module sim_spi_conv_frame_seq;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frame_start = 1'b0;
   logic [1:0]   chan_cfg = 2'b00;
   logic [127:0] dac_samples = '0;
   logic         busy, sclk, mosi, dac_cs_n, adc_cs_n, adc_valid;
   logic         miso = 1'b0;
   logic [2:0]   adc_chan;
   logic [15:0]  adc_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   spi_conv_frame_seq u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .chan_cfg(chan_cfg),
      .dac_samples(dac_samples), .busy(busy), .sclk(sclk), .mosi(mosi),
      .miso(miso), .dac_cs_n(dac_cs_n), .adc_cs_n(adc_cs_n),
      .adc_valid(adc_valid), .adc_chan(adc_chan), .adc_data(adc_data)
   );

   int map_tbl [8] = '{6, 4, 2, 0, 1, 3, 5, 7};

   function automatic logic [15:0] adc_value(input logic [2:0] ch);
      return {4'hA, 1'b0, ch, ~ch, 1'b1, 4'h5};
   endfunction

   // Slave models
   logic [31:0] dac_sh;
   int          dac_bits;
   logic [31:0] dac_log [16];
   int          dac_bits_log [16];
   int          dac_n = 0;
   logic [15:0] adc_sh, adc_resp;
   int          adc_bits;
   logic [15:0] adc_log [16];
   int          adc_bits_log [16];
   int          adc_n = 0;
   logic [2:0]  hist0 = 3'd0, hist1 = 3'd0;
   logic [2:0]  st_ch [16];
   logic [15:0] st_d [16];
   int          st_n = 0;
   int          overlap = 0;
   int          idle_sclk = 0;

   always @(negedge dac_cs_n) begin
      dac_bits = 0;
      dac_sh   = '0;
   end
   always @(posedge dac_cs_n) if (dac_n < 16) begin
      dac_log[dac_n]      = dac_sh;
      dac_bits_log[dac_n] = dac_bits;
      dac_n++;
   end
   always @(negedge adc_cs_n) begin
      adc_bits = 0;
      adc_sh   = '0;
      adc_resp = adc_value(hist1);
      miso     = adc_resp[15];
   end
   always @(posedge adc_cs_n) if (adc_n < 16) begin
      adc_log[adc_n]      = adc_sh;
      adc_bits_log[adc_n] = adc_bits;
      adc_n++;
      hist1 = hist0;
      hist0 = adc_sh[14:12];
   end
   always @(posedge sclk) begin
      if (!dac_cs_n) begin
         dac_sh = {dac_sh[30:0], mosi};
         dac_bits++;
      end else if (!adc_cs_n) begin
         adc_sh = {adc_sh[14:0], mosi};
         adc_bits++;
      end
   end
   always @(negedge sclk) begin
      if (!adc_cs_n) begin
         adc_resp = {adc_resp[14:0], 1'b0};
         miso     = adc_resp[15];
      end else if (!dac_cs_n) begin
         miso = ~miso;  // junk during DAC transfers
      end
   end
   always @(negedge clk) begin
      if (adc_valid && st_n < 16) begin
         st_ch[st_n] = adc_chan;
         st_d[st_n]  = adc_data;
         st_n++;
      end
      if (!dac_cs_n && !adc_cs_n) overlap++;
      if (dac_cs_n && adc_cs_n && sclk) idle_sclk++;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_logs();
      dac_n = 0; adc_n = 0; st_n = 0; overlap = 0; idle_sclk = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(dac_cs_n && adc_cs_n, "R1", "cs in reset", {dac_cs_n, adc_cs_n}, 2'b11);
      chk(!sclk && !busy && !adc_valid, "R1", "sclk/busy/valid in reset",
          {sclk, busy, adc_valid}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(dac_cs_n && adc_cs_n && !sclk && !busy && !adc_valid, "R1",
          "idle after reset", {dac_cs_n, adc_cs_n, sclk, busy, adc_valid}, 5'b11000);
      clear_logs();
   endtask

   task automatic run_frame(input logic [1:0] cfg, input logic [127:0] smp,
                            input bit primed, input bit extra_start, input string tag);
      int n, first, exp_st;
      n = (cfg == 2'b11) ? 8 : (cfg == 2'b01) ? 4 : 2;
      clear_logs();
      @(negedge clk);
      chan_cfg    = cfg;
      dac_samples = smp;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      dac_samples = ~smp;   // latched at start; later changes must not matter
      if (extra_start) begin
         repeat (150) @(negedge clk);
         chan_cfg    = 2'b11;
         frame_start = 1'b1;
         @(negedge clk);
         frame_start = 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(!busy, "R10", {tag, " busy after frame"}, busy, 0);
      chk(dac_n == n, "R2", {tag, " DAC transfer count"}, dac_n, n);
      chk(adc_n == n, "R2", {tag, " ADC transfer count"}, adc_n, n);
      chk(overlap == 0, "R6", {tag, " cs overlap"}, overlap, 0);
      chk(idle_sclk == 0, "R6", {tag, " sclk while idle"}, idle_sclk, 0);
      for (int k = 0; k < n && k < 16; k++) begin
         chk(dac_bits_log[k] == 32, "R4", {tag, " DAC bit count"}, dac_bits_log[k], 32);
         chk(dac_log[k][31:24] == 8'h03 && dac_log[k][3:0] == 4'h0, "R4",
             {tag, " DAC cmd/pad"}, dac_log[k], 32'h03000000);
         chk(dac_log[k][23:20] == 4'(map_tbl[k]), "R3", {tag, " DAC address"},
             dac_log[k][23:20], map_tbl[k]);
         chk(dac_log[k][19:4] == smp[16*k +: 16], "R5", {tag, " DAC sample"},
             dac_log[k][19:4], smp[16*k +: 16]);
         chk(adc_bits_log[k] == 16, "R7", {tag, " ADC bit count"}, adc_bits_log[k], 16);
         chk(adc_log[k] == {1'b0, 3'((k + 2) % n), 12'h000}, "R7",
             {tag, " ADC command"}, adc_log[k], {1'b0, 3'((k + 2) % n), 12'h000});
      end
      first  = primed ? 0 : 2;
      exp_st = (n > first) ? n - first : 0;
      chk(st_n == exp_st, "R9", {tag, " strobe count"}, st_n, exp_st);
      for (int i = 0; i < st_n && i < exp_st; i++) begin
         chk(st_ch[i] == 3'(first + i), "R8", {tag, " result channel"},
             st_ch[i], first + i);
         chk(st_d[i] == adc_value(3'(first + i)), "R8", {tag, " result data"},
             st_d[i], adc_value(3'(first + i)));
      end
   endtask

   function automatic logic [127:0] pattern(input logic [15:0] base);
      logic [127:0] p;
      for (int i = 0; i < 8; i++) p[16*i +: 16] = base + 16'(i * 16'h1111);
      return p;
   endfunction

   task automatic t_eight_after_reset();   // R9 priming, R3 full map
      run_frame(2'b11, pattern(16'h0123), 1'b0, 1'b0, "8ch-first");
   endtask
   task automatic t_four();
      run_frame(2'b01, pattern(16'h8F00), 1'b1, 1'b0, "4ch");
   endtask
   task automatic t_two();
      run_frame(2'b00, pattern(16'hFFFF), 1'b1, 1'b0, "2ch");
   endtask
   task automatic t_code_10();              // R2: code 2'b10 gives 2
      run_frame(2'b10, pattern(16'h5A5A), 1'b1, 1'b0, "code10");
   endtask
   task automatic t_start_while_busy();     // R10
      run_frame(2'b01, pattern(16'h1357), 1'b1, 1'b1, "busy-start");
   endtask
   task automatic t_reset_then_two();       // R9: both results suppressed
      t_reset();
      run_frame(2'b00, pattern(16'h2468), 1'b0, 1'b0, "2ch-after-reset");
      run_frame(2'b11, pattern(16'hC0DE), 1'b1, 1'b0, "8ch-primed");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_eight_after_reset();
      t_four();
      t_two();
      t_code_10();
      t_start_while_busy();
      t_reset_then_two();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule